// File: doc/BRIEF.md
# Ramp-Count Offset and Gain Corrector

This block turns a raw ramp count from a single-slope converter into an 8-bit code. The code is freed of both the zero offset and the gain error. Two calibration counts are held in registers. One is the count taken with the input tied to ground (the zero count). The other is the count taken with the input tied to the reference (the full-scale count). Each measurement count that arrives afterwards is corrected as round((N − zero) × 256 / (full − zero)). The ideal transfer of the converter is code = VIN × 256 / VREF, and this correction restores it.

The offset-free count is widened by an 8-bit left shift. Half the span is then added for rounding, and the sum goes through a restoring shift-subtract divider that produces one quotient bit per clock. The measurement input has a valid/ready handshake, and so does the result output. The calibration registers have simple load strobes. They keep their values until they are reloaded, so one calibration serves any number of measurements.

Top module: `zfs_corrector`

## Requirements
- R1: After reset, meas_ready is 1, res_valid is 0, and both calibration registers hold 0. A measurement made before any calibration is therefore reported as a calibration error.
- R2: With a valid calibration and N greater than the zero count, res_code equals floor(((N − Z) × 256 + floor(D/2)) / D), where Z is the zero count and D = F − Z for the full-scale count F. This rounds to nearest, and exact halves round up.
- R3: A measurement count less than or equal to the zero count gives res_code 0 with res_err 0.
- R4: A rounded quotient above 255 is saturated to 255. This includes N equal to the full-scale count, which rounds to 256.
- R5: When the full-scale count is less than or equal to the zero count, each result carries res_err = 1 and res_code = 0.
- R6: The calibration registers keep their values across any number of measurements. A load that occurs while a measurement is in progress affects only the measurements accepted after it.
- R7: A measurement is accepted on a clock edge where meas_valid and meas_ready are both 1. meas_ready stays 0 from acceptance until the result has been taken. While res_valid is 1 and res_ready is 0, res_valid, res_code and res_err hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nz_load | input | 1 | Strobe that writes nz_value into the zero-count register |
| nz_value | input | CNT_W | Ramp count measured on the ground channel |
| nfs_load | input | 1 | Strobe that writes nfs_value into the full-scale register |
| nfs_value | input | CNT_W | Ramp count measured on the reference channel |
| meas_valid | input | 1 | A measurement count is offered |
| meas_count | input | CNT_W | Raw measurement count |
| meas_ready | output | 1 | The block can accept a measurement |
| res_valid | output | 1 | A corrected result is present |
| res_ready | input | 1 | The consumer takes the result |
| res_code | output | OUT_W | Corrected, rounded and saturated code |
| res_err | output | 1 | The calibration was invalid for this result |

## Verification
Random calibration pairs are drawn with spans from 1 up to most of the count range, together with measurement counts spread below, inside and above the span. This mix separates faults in offset subtraction, gain scaling and saturation. Directed cases target details that random draws rarely hit:
- spans of 512 and 513 with an offset of 1, which separate round-half-up from truncation;
- a span of 1 and N equal to the full-scale count, which reach saturation;
- N equal to and below the zero count;
- equal and inverted calibrations.

A full-scale reload issued during a division shows whether the divisor was captured at acceptance. Results held with res_ready low show whether the output stays stable.

// File: rtl/zfs_corr_pkg.sv
package zfs_corr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } zfs_state_e;

endpackage

// File: rtl/zfs_cal_regs.sv
module zfs_cal_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nz_load,
  input  logic [CNT_W-1:0] nz_value,
  input  logic             nfs_load,
  input  logic [CNT_W-1:0] nfs_value,
  output logic [CNT_W-1:0] nz_q,
  output logic [CNT_W-1:0] span,
  output logic             cal_bad
);

  logic [CNT_W-1:0] nfs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q  <= '0;
      nfs_q <= '0;
    end else begin
      if (nz_load)  nz_q  <= nz_value;
      if (nfs_load) nfs_q <= nfs_value;
    end
  end

  assign cal_bad = (nfs_q <= nz_q);
  assign span    = nfs_q - nz_q;

  AST_NZ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !nz_load |=> $stable(nz_q)); // R6
  AST_NFS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !nfs_load |=> $stable(nfs_q)); // R6

endmodule

// File: rtl/zfs_rdiv.sv
module zfs_rdiv #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_sh;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem;
  logic [CW-1:0]    cnt;
  logic             busy;

  // one restoring step: bring down next dividend bit, try to subtract
  logic [DEN_W:0]   rem_sh;
  logic             fits;
  logic [DEN_W:0]   rem_nx;

  assign rem_sh = {rem, num_sh[NUM_W-1]};
  assign fits   = (rem_sh >= {1'b0, den_q});
  assign rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_sh <= '0;
      den_q  <= '0;
      rem    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      quo    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        num_sh <= num;
        den_q  <= den;
        rem    <= '0;
        quo    <= '0;
        cnt    <= CW'(NUM_W);
        busy   <= 1'b1;
      end else if (busy) begin
        num_sh <= num_sh << 1;
        rem    <= rem_nx[DEN_W-1:0];
        quo    <= {quo[NUM_W-2:0], fits};
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < den_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

endmodule

// File: rtl/zfs_corrector.sv
module zfs_corrector #(
  parameter int CNT_W = 16,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nz_load,
  input  logic [CNT_W-1:0] nz_value,
  input  logic             nfs_load,
  input  logic [CNT_W-1:0] nfs_value,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_count,
  output logic             meas_ready,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [OUT_W-1:0] res_code,
  output logic             res_err
);

  import zfs_corr_pkg::*;

  localparam int DW   = CNT_W + OUT_W + 1;
  localparam int QMAX = (1 << OUT_W) - 1;

  // offset-free count shifted up by OUT_W, plus half the span for rounding
  function automatic logic [DW-1:0] scaled_dividend(
    input logic [CNT_W-1:0] diff,
    input logic [CNT_W-1:0] spn
  );
    logic [DW-1:0] wide;
    wide = DW'(diff) << OUT_W;
    return wide + DW'(spn >> 1);
  endfunction

  function automatic logic [OUT_W-1:0] sat_code(input logic [DW-1:0] q);
    return (q > DW'(QMAX)) ? OUT_W'(QMAX) : q[OUT_W-1:0];
  endfunction

  zfs_state_e       state;
  logic [CNT_W-1:0] nz_q;
  logic [CNT_W-1:0] span;
  logic             cal_bad;
  logic             accept;
  logic             direct_zero;
  logic             div_start;
  logic             div_done;
  logic [DW-1:0]    div_quo;
  logic [DW-1:0]    dividend;

  zfs_cal_regs #(.CNT_W(CNT_W)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .nz_load  (nz_load),
    .nz_value (nz_value),
    .nfs_load (nfs_load),
    .nfs_value(nfs_value),
    .nz_q     (nz_q),
    .span     (span),
    .cal_bad  (cal_bad)
  );

  assign meas_ready  = (state == ST_IDLE);
  assign res_valid   = (state == ST_HOLD);
  assign accept      = meas_valid && meas_ready;
  assign direct_zero = (meas_count <= nz_q);
  assign div_start   = accept && !cal_bad && !direct_zero;
  assign dividend    = scaled_dividend(meas_count - nz_q, span);

  zfs_rdiv #(.NUM_W(DW), .DEN_W(CNT_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (dividend),
    .den  (span),
    .done (div_done),
    .quo  (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      res_code <= '0;
      res_err  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (cal_bad) begin
              res_code <= '0;
              res_err  <= 1'b1;
              state    <= ST_HOLD;
            end else if (direct_zero) begin
              res_code <= '0;
              res_err  <= 1'b0;
              state    <= ST_HOLD;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (div_done) begin
            res_code <= sat_code(div_quo);
            res_err  <= 1'b0;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_err))); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_code == '0)); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !meas_ready); // R7
  AST_DONE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (state == ST_RUN)); // R2

endmodule

// File: tb/tb_zfs_corrector.sv
module tb_zfs_corrector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nz_load = 1'b0;
  logic [15:0] nz_value = '0;
  logic        nfs_load = 1'b0;
  logic [15:0] nfs_value = '0;
  logic        meas_valid = 1'b0;
  logic [15:0] meas_count = '0;
  logic        meas_ready;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [7:0]  res_code;
  logic        res_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cz = 0;
  int cf = 0;

  always #2 clk = ~clk;

  zfs_corrector dut (
    .clk(clk), .rst_n(rst_n),
    .nz_load(nz_load), .nz_value(nz_value),
    .nfs_load(nfs_load), .nfs_value(nfs_value),
    .meas_valid(meas_valid), .meas_count(meas_count), .meas_ready(meas_ready),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_err(res_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected code, rounding written as floor((2x + D) / 2D)
  function automatic int ref_code(input int n, input int z, input int f);
    longint x, d, r;
    if (f <= z || n <= z) return 0;
    x = longint'(n - z) * 256;
    d = longint'(f - z);
    r = (2 * x + d) / (2 * d);
    if (r > 255) r = 255;
    return int'(r);
  endfunction

  task automatic load_cal(input int z, input int f);
    @(negedge clk);
    nz_load = 1'b1; nz_value = 16'(z);
    nfs_load = 1'b1; nfs_value = 16'(f);
    @(negedge clk);
    nz_load = 1'b0; nfs_load = 1'b0;
    cz = z; cf = f;
  endtask

  task automatic meas(input string req, input int n, input int hold,
                      input bit mid_reload, input int mid_f);
    int exp_c, exp_e, c, e;
    exp_c = ref_code(n, cz, cf);
    exp_e = (cf <= cz) ? 1 : 0;
    @(negedge clk);
    meas_count = 16'(n); meas_valid = 1'b1;
    while (!meas_ready) @(negedge clk);
    @(negedge clk);
    meas_valid = 1'b0;
    if (mid_reload) begin
      nfs_load = 1'b1; nfs_value = 16'(mid_f);
    end
    while (!res_valid) begin
      @(negedge clk);
      nfs_load = 1'b0;
      if (!res_valid) check("R7 ready low while busy", meas_ready, 0);
    end
    nfs_load = 1'b0;
    if (mid_reload) cf = mid_f;
    c = res_code; e = res_err;
    check(req, c, exp_c);
    check({req, " err"}, e, exp_e);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R7 held valid", res_valid, 1);
      check("R7 held code", res_code, c);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R7 released", res_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", meas_ready, 1);
    check("R1 no result after reset", res_valid, 0);
    meas("R1 uncalibrated", 100, 0, 1'b0, 0);

    load_cal(1000, 1000);
    meas("R5 equal calibration", 1500, 1, 1'b0, 0);
    load_cal(3000, 2000);
    meas("R5 inverted calibration", 2500, 0, 1'b0, 0);

    load_cal(1000, 1512);
    meas("R2 half rounds up", 1001, 0, 1'b0, 0);
    load_cal(1000, 1513);
    meas("R2 below half rounds down", 1001, 0, 1'b0, 0);
    load_cal(200, 40200);
    meas("R2 mid scale", 20200, 2, 1'b0, 0);
    meas("R3 equal to zero count", 200, 0, 1'b0, 0);
    meas("R3 below zero count", 17, 0, 1'b0, 0);
    meas("R4 at full scale", 40200, 0, 1'b0, 0);
    meas("R4 above full scale", 65535, 0, 1'b0, 0);
    load_cal(5, 6);
    meas("R4 unit span", 6, 0, 1'b0, 0);
    meas("R2 unit span zero", 5, 0, 1'b0, 0);

    load_cal(100, 10100);
    meas("R6 in-flight reload", 5100, 0, 1'b1, 20100);
    meas("R6 reload applies next", 5100, 0, 1'b0, 0);
    meas("R6 calibration persists", 15100, 0, 1'b0, 0);

    for (int k = 0; k < 240; k++) begin
      if (k % 16 == 0) begin
        int z, s;
        z = int'($urandom % 3000);
        s = 1 + int'($urandom % (60000 - z));
        if (k % 64 == 48) s = 1 + int'($urandom % 40);
        load_cal(z, z + s);
      end
      meas("R2 random", int'($urandom % 65536) % (cf + 400 + 1), int'($urandom % 3), 1'b0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule